// File: doc/BRIEF.md
# Predicated 16-bit ALU Execute Stage

This block is the execute stage of a small 16-bit processor core. It holds sixteen 16-bit general registers and a pair of result flags, zero and negative. Each cycle it may receive one decoded instruction word with a valid strobe. The word carries a two-bit predicate, and the predicate is compared with the live flags. When the predicate passes, the block performs one register-to-register operation, an add-immediate or a shift. The result is written to the destination register and the flags are refreshed from it.

Immediates are 4-bit two's-complement values taken from the source-register field, and they are remapped so that zero is never encoded. A non-negative value k means k+1, which gives 1 to 8. A negative value means its magnitude, which also gives 1 to 8, and the sign chooses the direction: subtract instead of add, or shift left instead of right. A separate read port shows any register's contents, so the surrounding core or a bench can observe the state.

Top module: `cond_alu_exec`

## Requirements
- R1: While reset is asserted, all registers read zero and both flags are 0. With both flags at 0, the positive predicate passes.
- R2: Instruction word layout is as follows. Bit 0 is the predicate zero bit pz. Bit 1 is the predicate negative bit pn. Bits 3:2 must be 00 for this block to act. Bits 7:4 are the op. Bits 11:8 select the source register a. Bits 15:12 select the destination register b.
- R3: The register ops and their codes in bits 7:4 are: 0000 b=b+a, 0010 b=b-a, 0100 b=b|a, 0110 b=b^a, 1000 b=b&a, 1010 b=~a, 1100 b=a. Each completes on the rising edge at which it is presented, and the new value reads back after that edge.
- R4: Op 0001 adds an immediate to register b. The immediate is bits 11:8 read as signed v. If v>=0, b=b+(v+1). If v<0, b=b-|v|.
- R5: Op 1110 shifts register b. The amount comes from bits 11:8 read as signed v. If v>=0, b is shifted right logically by v+1. If v<0, b is shifted left by |v|.
- R6: The predicate {pz,pn} decides whether the instruction runs. 11 always runs. 00 runs only when both flags are 0. 10 runs only when Z=1 and N=0. 01 runs only when N=1 and Z=0.
- R7: After an executed instruction, Z is 1 exactly when the 16-bit result is zero, and N equals bit 15 of the result.
- R8: An instruction has no effect on any register or flag in these cases: its predicate fails, valid is low, bits 3:2 are nonzero, or its op code is an odd value other than 0001. Such an instruction still takes its cycle.
- R9: When a and b name the same register, the operation reads the register's old value for both operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Decoded instruction word |
| rd_sel | input | 4 | Register index for the read port |
| rd_data | output | 16 | Contents of the register chosen by rd_sel |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The register write and the flag update land on the rising edge at which the instruction is presented. The read port is combinational, so each result is visible one clock edge after the stimulus, with no further latency. The bench drives each instruction and the read select on the falling edge. It samples rd_data and both flags on the next falling edge, which is half a cycle after the edge that wrote them. Skipped and ignored instructions are checked in the same slot, by reading back the destination register and the flags that they could have changed.

// File: rtl/cond_alu_exec.sv
module cond_alu_exec #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic [3:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              flag_z,
  output logic              flag_n
);
  localparam int NREG = 16;

  logic [DATA_W-1:0] rf [NREG];

  logic       pz, pn, pass, known, run;
  logic [3:0] op, sa, sb;
  logic [4:0] amt;
  logic [DATA_W-1:0] va, vb, res;

  assign pz = instr[0];
  assign pn = instr[1];
  assign op = instr[7:4];
  assign sa = instr[11:8];
  assign sb = instr[15:12];
  assign va = rf[sa];
  assign vb = rf[sb];

  assign pass  = (pz & pn) | ((pz == flag_z) & (pn == flag_n));
  assign known = ~op[0] | (op == 4'b0001);
  assign run   = instr_valid & (instr[3:2] == 2'b00) & known & pass;

  assign amt = sa[3] ? (5'd16 - {1'b0, sa}) : ({1'b0, sa} + 5'd1);

  always_comb begin
    case (op)
      4'b0000: res = vb + va;
      4'b0010: res = vb - va;
      4'b0100: res = vb | va;
      4'b0110: res = vb ^ va;
      4'b1000: res = vb & va;
      4'b1010: res = ~va;
      4'b1100: res = va;
      4'b1110: res = sa[3] ? (vb << amt) : (vb >> amt);
      4'b0001: res = sa[3] ? (vb - DATA_W'(amt)) : (vb + DATA_W'(amt));
      default: res = vb;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else if (run) begin
      rf[sb] <= res;
      flag_z <= (res == '0);
      flag_n <= res[DATA_W-1];
    end
  end

  assign rd_data = rf[rd_sel];
endmodule

// File: rtl/cond_alu_exec_chk.sv
module cond_alu_exec_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [15:0]       instr,
  input logic [3:0]        rd_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              flag_z,
  input logic              flag_n
);
  a_r1_reset_flags: assert property (@(posedge clk)
    !rst_n |=> (!flag_z && !flag_n));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_z && flag_n));

  a_r8_idle_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable({flag_z, flag_n}));

  a_r6_fail_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !(instr[0] && instr[1]) &&
     ((instr[0] != flag_z) || (instr[1] != flag_n))) |=> $stable({flag_z, flag_n}));

  a_r8_idle_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid ##1 $stable(rd_sel) |-> $stable(rd_data));
endmodule

bind cond_alu_exec cond_alu_exec_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/cond_alu_exec_tb_top.sv
module cond_alu_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        flag_z, flag_n;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cond_alu_exec dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .rd_sel(rd_sel), .rd_data(rd_data), .flag_z(flag_z), .flag_n(flag_n)
  );

  function automatic logic [15:0] mk(logic z, logic n, logic [3:0] op,
                                     logic [3:0] a, logic [3:0] b);
    return {b, a, op, 2'b00, n, z};
  endfunction

  localparam logic [3:0] ADD = 4'b0000, SUB = 4'b0010, OR_ = 4'b0100,
    XOR = 4'b0110, AND = 4'b1000, NOT = 4'b1010, CPY = 4'b1100,
    SHF = 4'b1110, ADI = 4'b0001;

  localparam int NV = 23;
  // {instr, reg to read, expected data, expected z, expected n}
  localparam logic [37:0] VEC [NV] = '{
    {mk(1,1,ADI,4'h7,4'd1), 4'd1, 16'h0008, 1'b0, 1'b0},  // R4 +8
    {mk(1,1,SHF,4'hE,4'd1), 4'd1, 16'h0020, 1'b0, 1'b0},  // R5 left 2
    {mk(1,1,ADI,4'hF,4'd2), 4'd2, 16'hFFFF, 1'b0, 1'b1},  // R4 -1
    {mk(1,1,ADD,4'd1,4'd2), 4'd2, 16'h001F, 1'b0, 1'b0},  // R3 add
    {mk(1,1,SUB,4'd1,4'd2), 4'd2, 16'hFFFF, 1'b0, 1'b1},  // R3 sub
    {mk(1,1,SHF,4'h3,4'd2), 4'd2, 16'h0FFF, 1'b0, 1'b0},  // R5 right 4
    {mk(1,1,OR_,4'd1,4'd3), 4'd3, 16'h0020, 1'b0, 1'b0},  // R3 or
    {mk(1,1,XOR,4'd2,4'd3), 4'd3, 16'h0FDF, 1'b0, 1'b0},  // R3 xor
    {mk(1,1,AND,4'd1,4'd3), 4'd3, 16'h0000, 1'b1, 1'b0},  // R3 and, R7 zero
    {mk(1,1,NOT,4'd3,4'd4), 4'd4, 16'hFFFF, 1'b0, 1'b1},  // R3 not
    {mk(1,1,CPY,4'd1,4'd5), 4'd5, 16'h0020, 1'b0, 1'b0},  // R3 copy
    {mk(1,1,SUB,4'd5,4'd5), 4'd5, 16'h0000, 1'b1, 1'b0},  // R9 same reg
    {mk(1,0,ADI,4'h0,4'd6), 4'd6, 16'h0001, 1'b0, 1'b0},  // R6 zero pass
    {mk(1,0,ADI,4'h0,4'd6), 4'd6, 16'h0001, 1'b0, 1'b0},  // R6 zero fail
    {mk(0,1,ADI,4'h0,4'd6), 4'd6, 16'h0001, 1'b0, 1'b0},  // R6 neg fail
    {mk(0,0,ADI,4'h8,4'd6), 4'd6, 16'hFFF9, 1'b0, 1'b1},  // R6 pos pass, R4 -8
    {mk(0,1,NOT,4'd0,4'd7), 4'd7, 16'hFFFF, 1'b0, 1'b1},  // R6 neg pass
    {mk(0,0,CPY,4'd0,4'd7), 4'd7, 16'hFFFF, 1'b0, 1'b1},  // R6 pos fail
    {mk(1,1,4'b0011,4'd0,4'd7), 4'd7, 16'hFFFF, 1'b0, 1'b1},  // R8 odd op
    {mk(1,1,CPY,4'd0,4'd7) | 16'h0008, 4'd7, 16'hFFFF, 1'b0, 1'b1},  // R8 class bits
    {mk(1,1,SHF,4'h7,4'd4), 4'd4, 16'h00FF, 1'b0, 1'b0},  // R5 right 8
    {mk(1,1,SHF,4'h8,4'd4), 4'd4, 16'hFF00, 1'b0, 1'b1},  // R5 left 8
    {mk(1,1,ADI,4'h7,4'd4), 4'd4, 16'hFF08, 1'b0, 1'b1}   // R4 +8
  };

  task automatic chk(string req, logic [17:0] got, logic [17:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got data=%h z=%b n=%b expected data=%h z=%b n=%b",
               req, got[17:2], got[1], got[0], exp[17:2], exp[1], exp[0]);
    end
  endtask

  task automatic step(logic v, logic [15:0] w, logic [3:0] sel);
    @(negedge clk);
    instr_valid = v;
    instr = w;
    rd_sel = sel;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int r = 0; r < 16; r++) begin
      rd_sel = 4'(r);
      #1;
      chk("R1 reset", {rd_data, flag_z, flag_n}, 18'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][37:22], VEC[i][21:18]);
      chk($sformatf("R2/R3-R9 vector %0d", i), {rd_data, flag_z, flag_n}, VEC[i][17:0]);
    end

    // R8: valid low, with an instruction that would otherwise change r4
    step(1'b0, mk(1,1,CPY,4'd0,4'd4), 4'd4);
    chk("R8 valid low", {rd_data, flag_z, flag_n}, {16'hFF08, 1'b0, 1'b1});

    // R1: reset mid-run clears state again
    @(negedge clk);
    rst_n = 1'b0;
    rd_sel = 4'd4;
    @(negedge clk);
    chk("R1 reset again", {rd_data, flag_z, flag_n}, 18'h0);
    rst_n = 1'b1;

    // R6: after reset the positive predicate passes
    step(1'b1, mk(0,0,ADI,4'h2,4'd9), 4'd9);
    chk("R6 positive after reset", {rd_data, flag_z, flag_n}, {16'h0003, 1'b0, 1'b0});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule